// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when an asynchronous DRAM with multiplexed addresses needs a refresh cycle. It does not drive RAS or CAS. It raises a request towards the memory arbiter, and the arbiter answers with a grant in the cycle it runs the refresh. After reset the block waits out the power-up pause. It then asks for a short burst of start-up refreshes and only after that declares the memory usable. In normal operation one refresh falls due per row interval, so that every row is covered within the retention time. The retention time is short in the standard-power setting and four times longer in the low-power setting.

Two row-selection styles are supported. In counter mode the device's own row counter picks the row, and the scheduler issues CAS-before-RAS requests. In explicit-row mode the scheduler supplies the row on `ref_row` and moves it on after each refresh. The host can also park the device in self refresh through a level request. The scheduler then runs whatever catch-up each style needs on the way in and on the way out.

Top module: `rfs_refresh_sched`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `ref_req`, `ready` and `sleep_ok` are 0 and `ref_row` is 0.
- R2: For the first PAUSE_US×CLK_MHZ clock cycles after reset, `ref_req` stays 0. It rises in the next cycle.
- R3: After the pause, `ref_req` is held at 1 until 8 refreshes are accepted. A refresh is accepted in any cycle where `ref_req` and `ref_gnt` are both 1.
- R4: `ready` stays 0 until the eighth start-up refresh is accepted and rises in the following cycle. After that it stays 1 until reset.
- R5: Once `ready` is 1, one refresh falls due every floor(RETAIN_MS×1000×CLK_MHZ/2048) cycles. RETAIN_MS is 32 when `cfg_low_power` is 0 and 128 when it is 1. With the grant held high, the requests are exactly that far apart.
- R6: Refreshes that fall due but are not yet granted are counted, up to a ceiling of 8. Further due refreshes are dropped. `ref_req` stays 1 while the count is nonzero, and each accepted refresh lowers it by one.
- R7: A grant while `ref_req` is 0 has no effect: `ref_row` does not change and no refresh is taken from the outstanding count.
- R8: `ref_row` (11 bits) advances by one for every accepted refresh and wraps from 2047 to 0.
- R9: Self-refresh entry in counter mode (`cfg_ras_only` = 0): when `sleep_req` is seen at 1 in normal operation, `sleep_ok` is 1 in the next cycle and the outstanding count is discarded. `ref_req` is 0 while `sleep_ok` is 1.
- R10: Self-refresh entry in explicit-row mode (`cfg_ras_only` = 1): exactly 2048 refreshes are requested back to back before `sleep_ok` rises.
- R11: When `sleep_req` falls in counter mode, exactly one refresh is requested. Normal interval operation then restarts with nothing outstanding.
- R12: When `sleep_req` falls in explicit-row mode, exactly 2048 refreshes are requested back to back before normal operation resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_low_power | input | 1 | 1 selects the 128 ms retention interval, 0 selects 32 ms |
| cfg_ras_only | input | 1 | 1 selects explicit-row refresh, 0 selects the device's internal counter |
| sleep_req | input | 1 | Level request to hold the device in self refresh |
| ref_gnt | input | 1 | Arbiter runs the requested refresh in this cycle |
| ref_req | output | 1 | A refresh cycle is wanted |
| ref_row | output | 11 | Row for an explicit-row refresh |
| ready | output | 1 | Start-up sequence is complete; normal accesses may start |
| sleep_ok | output | 1 | The device may stay in self refresh |

## Verification
Every output is a function of registers, so a change on an input is visible one clock later.

The expected latencies are as follows:
- **Grant:** an accepted grant moves `ref_row`, and clears a single outstanding request, one cycle later.
- **Interval:** a refresh that falls due raises `ref_req` one cycle after the interval counter wraps.
- **Sleep entry:** `sleep_ok` follows `sleep_req` by one cycle in counter mode. In explicit-row mode it follows the 2048th burst grant by one cycle.
- **Start-up:** `ready` follows the eighth start-up grant by one cycle.

The bench samples on the falling edge. It compares every output against its own timed model on each cycle. Its directed checks count falling edges from the stimulus to the exact cycle in which each result is due.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        PH_PAUSE = 3'd0,
        PH_INIT  = 3'd1,
        PH_RUN   = 3'd2,
        PH_PRE   = 3'd3,
        PH_SLEEP = 3'd4,
        PH_POST  = 3'd5
    } rfs_phase_e;

    // clock cycles available per row when all rows share one retention window
    function automatic int unsigned cycles_per_row(input int unsigned retain_ms,
                                                   input int unsigned clk_mhz,
                                                   input int unsigned rows);
        return (retain_ms * 1000 * clk_mhz) / rows;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfs_tick_counter.sv
module rfs_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    // >= keeps the counter bounded when the limit shrinks mid-count
    assign tick = en && (cnt_q >= (limit - W'(1)));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr #(
    parameter int MAX = 8,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] level
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level <= '0;
        end else if (inc && !dec) begin
            if (level < W'(MAX)) begin
                level <= level + W'(1);
            end
        end else if (dec && !inc) begin
            if (level != '0) begin
                level <= level - W'(1);
            end
        end
    end
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int BITS = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    output logic [BITS-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (step) begin
            row <= row + BITS'(1);
        end
    end
endmodule

// File: rtl/rfs_refresh_sched.sv
module rfs_refresh_sched #(
    parameter int CLK_MHZ        = 100,
    parameter int PAUSE_US       = 200,
    parameter int INIT_REFRESHES = 8,
    parameter int ROW_BITS       = 11,
    parameter int RETAIN_SP_MS   = 32,
    parameter int RETAIN_LP_MS   = 128,
    parameter int PEND_MAX       = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_low_power,
    input  logic                cfg_ras_only,
    input  logic                sleep_req,
    input  logic                ref_gnt,
    output logic                ref_req,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                ready,
    output logic                sleep_ok
);
    import rfs_pkg::*;

    localparam int unsigned ROWS      = 1 << ROW_BITS;
    localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_MHZ;
    localparam int unsigned INT_SP    = cycles_per_row(RETAIN_SP_MS, CLK_MHZ, ROWS);
    localparam int unsigned INT_LP    = cycles_per_row(RETAIN_LP_MS, CLK_MHZ, ROWS);
    localparam int          CNT_W     = $clog2(max3(PAUSE_CYC, INT_SP, INT_LP) + 1);
    localparam int          PEND_W    = $clog2(PEND_MAX + 1);
    localparam int          REM_W     = $clog2(ROWS + 1);

    rfs_phase_e        state_q;
    logic [REM_W-1:0]  remain_q;
    logic [PEND_W-1:0] pend_level;
    logic [CNT_W-1:0]  ivl_limit;
    logic              pause_tick;
    logic              ivl_tick;
    logic              accept;
    logic              in_run;
    logic              in_burst;

    assign in_run   = (state_q == PH_RUN);
    assign in_burst = (state_q == PH_INIT) || (state_q == PH_PRE) || (state_q == PH_POST);

    assign ref_req  = in_burst || (in_run && (pend_level != '0));
    assign accept   = ref_req && ref_gnt;
    assign ready    = (state_q != PH_PAUSE) && (state_q != PH_INIT);
    assign sleep_ok = (state_q == PH_SLEEP);

    assign ivl_limit = cfg_low_power ? CNT_W'(INT_LP) : CNT_W'(INT_SP);

    rfs_tick_counter #(.W(CNT_W)) u_pause (
        .clk   (clk),
        .rst   (rst),
        .en    (state_q == PH_PAUSE),
        .limit (CNT_W'(PAUSE_CYC)),
        .tick  (pause_tick)
    );

    rfs_tick_counter #(.W(CNT_W)) u_interval (
        .clk   (clk),
        .rst   (rst),
        .en    (in_run),
        .limit (ivl_limit),
        .tick  (ivl_tick)
    );

    rfs_pending_ctr #(.MAX(PEND_MAX), .W(PEND_W)) u_pending (
        .clk   (clk),
        .rst   (rst),
        .clr   (!in_run),
        .inc   (ivl_tick),
        .dec   (accept),
        .level (pend_level)
    );

    rfs_row_ctr #(.BITS(ROW_BITS)) u_row (
        .clk  (clk),
        .rst  (rst),
        .step (accept),
        .row  (ref_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_PAUSE;
            remain_q <= '0;
        end else begin
            case (state_q)
                PH_PAUSE: begin
                    if (pause_tick) begin
                        state_q  <= PH_INIT;
                        remain_q <= REM_W'(INIT_REFRESHES);
                    end
                end
                PH_INIT, PH_PRE, PH_POST: begin
                    if (accept) begin
                        remain_q <= remain_q - REM_W'(1);
                        if (remain_q == REM_W'(1)) begin
                            state_q <= (state_q == PH_PRE) ? PH_SLEEP : PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    if (sleep_req) begin
                        if (cfg_ras_only) begin
                            state_q  <= PH_PRE;
                            remain_q <= REM_W'(ROWS);
                        end else begin
                            state_q <= PH_SLEEP;
                        end
                    end
                end
                PH_SLEEP: begin
                    if (!sleep_req) begin
                        state_q  <= PH_POST;
                        remain_q <= cfg_ras_only ? REM_W'(ROWS) : REM_W'(1);
                    end
                end
                default: state_q <= PH_PAUSE;
            endcase
        end
    end
endmodule

// File: rtl/rfs_sched_checks.sv
module rfs_sched_checks #(
    parameter int unsigned PAUSE_CYC = 20000,
    parameter int          PEND_MAX  = 8,
    parameter int          ROW_BITS  = 11,
    parameter int          PEND_W    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                ref_req,
    input logic                ref_gnt,
    input logic [ROW_BITS-1:0] ref_row,
    input logic                ready,
    input logic                sleep_ok,
    input logic [PEND_W-1:0]   pend_level
);
    logic [31:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < PAUSE_CYC) begin
            since_rst <= since_rst + 32'd1;
        end
    end

    p_quiet_pause_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst < PAUSE_CYC) |-> !ref_req);

    p_ready_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    p_ready_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(ref_req && ref_gnt));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        pend_level <= PEND_W'(PEND_MAX));

    p_row_step_r8: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_gnt) |=> (ref_row == ROW_BITS'($past(ref_row) + 1'b1)));

    p_row_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(ref_req && ref_gnt) |=> $stable(ref_row));

    p_quiet_sleep_r9: assert property (@(posedge clk) disable iff (rst)
        sleep_ok |-> !ref_req);
endmodule

bind rfs_refresh_sched rfs_sched_checks #(
    .PAUSE_CYC (PAUSE_CYC),
    .PEND_MAX  (PEND_MAX),
    .ROW_BITS  (ROW_BITS),
    .PEND_W    (PEND_W)
) u_checks (
    .clk        (clk),
    .rst        (rst),
    .ref_req    (ref_req),
    .ref_gnt    (ref_gnt),
    .ref_row    (ref_row),
    .ready      (ready),
    .sleep_ok   (sleep_ok),
    .pend_level (pend_level)
);

// File: tb/test_rfs_refresh_sched.sv
`timescale 1ns/1ps
module test_rfs_refresh_sched;
    localparam int PAUSE = 200;   // 200 us at 1 MHz
    localparam int I_SP  = 15;    // 32000 / 2048
    localparam int I_LP  = 62;    // 128000 / 2048
    localparam int NROWS = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp = 1'b0, ras = 1'b0, slp = 1'b0, gnt = 1'b0;
    logic ref_req, ready, sleep_ok;
    logic [10:0] ref_row;

    int n_chk = 0, n_err = 0, cyc = 0;

    always #5 clk = ~clk;

    rfs_refresh_sched #(.CLK_MHZ(1)) i_rfs_refresh_sched (
        .clk(clk), .rst(rst), .cfg_low_power(lp), .cfg_ras_only(ras),
        .sleep_req(slp), .ref_gnt(gnt), .ref_req(ref_req), .ref_row(ref_row),
        .ready(ready), .sleep_ok(sleep_ok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // behavioural reference: 0 pause, 1 start-up, 2 normal, 3 pre-sleep, 4 asleep, 5 wake-up
    int m_st = 0, m_pc = 0, m_tc = 0, m_pend = 0, m_rem = 0, m_row = 0;
    int m_lim;
    bit m_acc, m_pt, m_it;

    function automatic bit m_req();
        return (m_st == 1) || (m_st == 3) || (m_st == 5) || (m_st == 2 && m_pend > 0);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog all requirements actual=%0d expected<150000", cyc);
            finish_run();
        end
        if (rst) begin
            m_st = 0; m_pc = 0; m_tc = 0; m_pend = 0; m_rem = 0; m_row = 0;
        end else begin
            m_acc = m_req() && gnt;
            m_pt  = (m_st == 0) && (m_pc == PAUSE - 1);
            m_lim = lp ? I_LP : I_SP;
            m_it  = (m_st == 2) && (m_tc >= m_lim - 1);
            m_pc  = (m_st == 0) ? (m_pt ? 0 : m_pc + 1) : 0;
            m_tc  = (m_st == 2) ? (m_it ? 0 : m_tc + 1) : 0;
            if (m_st != 2) m_pend = 0;
            else if (m_it && !m_acc && m_pend < 8) m_pend++;
            else if (m_acc && !m_it && m_pend > 0) m_pend--;
            if (m_acc) m_row = (m_row + 1) % NROWS;
            case (m_st)
                0: if (m_pt) begin m_st = 1; m_rem = 8; end
                1, 3, 5: if (m_acc) begin
                    if (m_rem == 1) m_st = (m_st == 3) ? 4 : 2;
                    m_rem--;
                end
                2: if (slp) begin
                    if (ras) begin m_st = 3; m_rem = NROWS; end
                    else m_st = 4;
                end
                4: if (!slp) begin m_st = 5; m_rem = ras ? NROWS : 1; end
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R6 ref_req vs model", ref_req, m_req());
            chk("R4 ready vs model", ready, (m_st != 0 && m_st != 1));
            chk("R9 sleep_ok vs model", sleep_ok, (m_st == 4));
            chk("R8 ref_row vs model", ref_row, m_row);
        end
    end

    initial begin
        int d, n, r0;
        bit wrapped;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 req in reset", ref_req, 0);
        chk("R1 ready in reset", ready, 0);
        chk("R1 sleep_ok in reset", sleep_ok, 0);
        chk("R1 row in reset", ref_row, 0);
        rst = 1'b0;
        chk("R1 req after reset", ref_req, 0);
        // R2 pause length
        repeat (PAUSE - 1) @(negedge clk);
        chk("R2 no req at end of pause", ref_req, 0);
        @(negedge clk);
        chk("R2 req after pause", ref_req, 1);
        // R3/R4 start-up burst
        gnt = 1'b1;
        repeat (7) @(negedge clk);
        chk("R3 req held during start-up", ref_req, 1);
        chk("R4 ready low before 8th", ready, 0);
        @(negedge clk);
        chk("R4 ready after 8th refresh", ready, 1);
        chk("R3 row after start-up", ref_row, 8);
        // R6 saturation of outstanding refreshes
        gnt = 1'b0;
        repeat (200) @(negedge clk);
        chk("R6 req while outstanding", ref_req, 1);
        gnt = 1'b1;
        n = 0;
        while (ref_req) begin n++; @(negedge clk); end
        chk("R6 drained count within ceiling", (n == 8 || n == 9) ? 1 : 0, 1);
        // R5 interval, standard power
        d = 0;
        while (!ref_req) @(negedge clk);
        @(negedge clk); d = 1;
        while (!ref_req) begin @(negedge clk); d++; end
        chk("R5 standard-power interval", d, I_SP);
        // R5 interval, low power
        lp = 1'b1;
        for (int k = 0; k < 2; k++) begin
            while (!ref_req) @(negedge clk);
            @(negedge clk); d = 1;
            while (!ref_req) begin @(negedge clk); d++; end
        end
        chk("R5 low-power interval", d, I_LP);
        // R7 grant without request
        @(negedge clk);
        r0 = ref_row;
        repeat (10) @(negedge clk);
        chk("R7 row unchanged by idle grant", ref_row, r0);
        chk("R7 no request from idle grant", ref_req, 0);
        lp = 1'b0;
        // R9/R11 counter-mode sleep
        ras = 1'b0; gnt = 1'b0;
        repeat (40) @(negedge clk);
        slp = 1'b1;
        @(negedge clk);
        chk("R9 sleep_ok one cycle after request", sleep_ok, 1);
        n = 0;
        repeat (50) begin @(negedge clk); if (ref_req) n++; end
        chk("R9 no requests while asleep", n, 0);
        slp = 1'b0; gnt = 1'b1;
        @(negedge clk);
        n = 0;
        while (ref_req) begin n++; @(negedge clk); end
        chk("R11 single refresh on counter-mode exit", n, 1);
        chk("R11 sleep_ok low after exit", sleep_ok, 0);
        // R10/R12/R8 explicit-row sleep
        ras = 1'b1;
        while (!ref_req) @(negedge clk);
        r0 = ref_row;
        slp = 1'b1;
        @(negedge clk);
        n = 0; wrapped = 1'b0;
        while (!sleep_ok) begin
            if (ref_req) n++;
            if (ref_row == 11'd2047) begin
                @(negedge clk);
                if (ref_row == 11'd0) wrapped = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        chk("R10 refreshes before sleep", n, NROWS);
        chk("R8 row wrapped 2047 to 0", wrapped, 1);
        chk("R8 row after full set", ref_row, (r0 + 1) % NROWS);
        slp = 1'b0;
        @(negedge clk);
        n = 0;
        while (ref_req) begin n++; @(negedge clk); end
        chk("R12 refreshes after wake-up", n, NROWS);
        chk("R12 ready kept", ready, 1);
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule